// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block is the interrupt front end of a 32-pin general-purpose I/O port. Each pin input is synchronised through two flip-flops. A per-pin detector then turns it into events, according to a 2-bit sense code and a level/edge select bit. The events collect in a pending register that software clears by writing ones. A mask register decides which pending bits drive the single combined interrupt line. The block also holds the port's direction register. A build-time parameter marks four pins as input-only, and the block refuses to make those pins outputs.

Throughout, pin n sits at bit 31-n of `pin_in`, `pin_dir` and of the direction, mask, pending and level-select registers. The sense codes are packed two bits per pin into two configuration registers in descending pin order. A bus master reaches all registers through a simple word interface: a write strobe, a 3-bit register index, write data, and read data that follows the index combinationally.

Top module: `pin_sense_irq`

Register indices: 0 direction, 1 mask, 2 pending (write 1 to clear), 3 low configuration (pins 0-15), 4 high configuration (pins 16-31), 5 level select. The other indices read zero.

## Requirements
- R1: After reset, the direction, mask, pending, both configuration and level-select registers all read 0, and `irq` is low.
- R2: The sense code of pin n (n < 16) is in the low configuration register at bits [2*(15-n)+1 : 2*(15-n)]. The code of pin n (n >= 16) is in the high configuration register at bits [2*(15-(n-16))+1 : 2*(15-(n-16))]. Both registers read back as written.
- R3: Code 00 sets the pin's pending bit on both a rising and a falling input transition, whatever the level-select bit holds.
- R4: Code 01 with level-select 0 reacts to rising transitions only. With level-select 1 it reacts to a high input.
- R5: Code 10 with level-select 0 reacts to falling transitions only. With level-select 1 it reacts to a low input.
- R6: Code 11 never sets a pending bit.
- R7: Writing to the pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: `irq` is high exactly when some pending bit is set and its mask bit is 1.
- R9: In level mode, the pending bit is set again on every cycle the condition holds. A clear in the same cycle as a set leaves the bit set.
- R10: With RO_LOW_GROUP = 0, pins 28-31 (bits 3:0) are input-only. With RO_LOW_GROUP = 1, pins 0-3 (bits 31:28) are input-only. Writes cannot set the direction bits of these pins to 1 (output); they stay 0.
- R11: A pin change that arrives before rising clock edge k shows in the pending register after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Raw pin inputs, pin n at bit 31-n |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_dir | output | 32 | Direction per pin, 1 = output |
| irq | output | 1 | Combined masked interrupt |

## Verification
Suppose a configuration field is decoded at the wrong position. Then a wrong pending bit appears, or none does, three edges after the stimulus pin toggles, and the pending read shows it at once. A detector with the wrong edge or level meaning shows up as an event where none is due, or a missing one, within the same three cycles. A bad set-over-clear priority shows as a bit that clears while its level still holds, on the cycle right after the clear write. A leak in the input-only guard appears on `pin_dir` directly after the write.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned NPIN  = 32;
  localparam int unsigned HALF  = NPIN / 2;
  localparam int unsigned CODEW = 2;
  localparam int unsigned NRO   = 4;
  localparam int unsigned AW    = 3;

  typedef enum logic [CODEW-1:0] {
    SENSE_ANY = 2'b00,
    SENSE_HI  = 2'b01,
    SENSE_LO  = 2'b10,
    SENSE_OFF = 2'b11
  } sense_e;

  typedef enum logic [AW-1:0] {
    RA_DIR  = 3'd0,
    RA_MASK = 3'd1,
    RA_PEND = 3'd2,
    RA_CFGL = 3'd3,
    RA_CFGH = 3'd4,
    RA_LVL  = 3'd5
  } reg_addr_e;

  // Sense code of register bit b (pin 31-b); bits at or above HALF use the low register.
  function automatic logic [CODEW-1:0] code_of(input logic [NPIN-1:0] lo,
                                               input logic [NPIN-1:0] hi,
                                               input int unsigned b);
    if (b >= HALF) return lo[CODEW*(b-HALF) +: CODEW];
    else           return hi[CODEW*b +: CODEW];
  endfunction

  // Direction bits held at input for the selected restricted group.
  function automatic logic [NPIN-1:0] ro_mask(input bit low_group);
    logic [NPIN-1:0] m;
    m = '0;
    for (int i = 0; i < NRO; i++) begin
      if (low_group) m[NPIN-1-i] = 1'b1;
      else           m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pss_detect.sv
module pss_detect
  import pss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur,
  input  logic [CODEW-1:0] code,
  input  logic             lvl_mode,
  output logic             evt
);
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    case (sense_e'(code))
      SENSE_ANY: evt = rise | fall;
      SENSE_HI:  evt = lvl_mode ? cur : rise;
      SENSE_LO:  evt = lvl_mode ? ~cur : fall;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/pss_pending.sv
module pss_pending #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pin_sense_irq.sv
module pin_sense_irq
  import pss_pkg::*;
#(
  parameter bit RO_LOW_GROUP = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  output logic [NPIN-1:0] pin_dir,
  output logic            irq
);
  localparam logic [NPIN-1:0] RO_BITS = ro_mask(RO_LOW_GROUP);

  logic [NPIN-1:0] dir_q, mask_q, cfg_lo_q, cfg_hi_q, lvl_q;
  logic [NPIN-1:0] pend_q;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] evt_vec;
  logic [NPIN-1:0] clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      mask_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      lvl_q    <= '0;
    end else if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        RA_DIR:  dir_q    <= bus_wdata & ~RO_BITS;
        RA_MASK: mask_q   <= bus_wdata;
        RA_CFGL: cfg_lo_q <= bus_wdata;
        RA_CFGH: cfg_hi_q <= bus_wdata;
        RA_LVL:  lvl_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_vec = (bus_wr && reg_addr_e'(bus_addr) == RA_PEND) ? bus_wdata : '0;

  pss_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  for (genvar b = 0; b < NPIN; b++) begin : g_det
    pss_detect u_det (
      .clk(clk), .rst_n(rst_n), .cur(pin_s[b]),
      .code(code_of(cfg_lo_q, cfg_hi_q, b)),
      .lvl_mode(lvl_q[b]), .evt(evt_vec[b])
    );
  end

  pss_pending #(.W(NPIN)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_vec), .clr_vec(clr_vec), .pend(pend_q)
  );

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_DIR:  bus_rdata = dir_q;
      RA_MASK: bus_rdata = mask_q;
      RA_PEND: bus_rdata = pend_q;
      RA_CFGL: bus_rdata = cfg_lo_q;
      RA_CFGH: bus_rdata = cfg_hi_q;
      RA_LVL:  bus_rdata = lvl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_dir = dir_q;
  assign irq     = |(pend_q & mask_q);
endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
#(
  parameter bit RO_LOW_GROUP = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_dir,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] pend_q,
  input logic [NPIN-1:0] cfg_lo_q,
  input logic [NPIN-1:0] cfg_hi_q,
  input logic [NPIN-1:0] evt_vec,
  input logic [NPIN-1:0] clr_vec,
  input logic            irq
);
  localparam logic [NPIN-1:0] RO_BITS = ro_mask(RO_LOW_GROUP);

  logic [NPIN-1:0] reserved;
  for (genvar b = 0; b < NPIN; b++) begin : g_res
    assign reserved[b] = (code_of(cfg_lo_q, cfg_hi_q, b) == 2'b11);
  end

  p_ro_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_dir & RO_BITS) == '0);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec & ~evt_vec)) == '0));

  p_set_needs_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_vec)) == '0));

  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & reserved) == '0);

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind pin_sense_irq pss_checker #(.RO_LOW_GROUP(RO_LOW_GROUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_dir(pin_dir), .mask_q(mask_q), .pend_q(pend_q),
  .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q), .evt_vec(evt_vec), .clr_vec(clr_vec),
  .irq(irq)
);

// File: tb/sim_pin_sense_irq.sv
`timescale 1ns/1ps
module sim_pin_sense_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_dir;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          use_irq;
    bit          use_dir;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pin_sense_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_dir(pin_dir), .irq(irq)
  );

  // Monitor: pops each expected item and compares against the ports.
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        if (it.use_irq)      act = {31'b0, irq};
        else if (it.use_dir) act = pin_dir;
        else                 act = bus_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.use_irq = 1'b0; it.use_dir = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic chk_port(input bit is_irq, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.use_irq = is_irq; it.use_dir = !is_irq; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic setpin(input int b, input logic v);
    @(negedge clk);
    pin_in[b] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(3'd0, 32'h0, "R1 dir");
    chk(3'd1, 32'h0, "R1 mask");
    chk(3'd2, 32'h0, "R1 pend");
    chk(3'd3, 32'h0, "R1 cfg_lo");
    chk(3'd4, 32'h0, "R1 cfg_hi");
    chk(3'd5, 32'h0, "R1 lvl");
    chk_port(1'b1, 32'h0, "R1 irq");

    // R10 input-only pins 28-31 at bits 3:0
    wr(3'd0, 32'hFFFF_FFFF);
    chk(3'd0, 32'hFFFF_FFF0, "R10 dir readback");
    chk_port(1'b0, 32'hFFFF_FFF0, "R10 pin_dir");
    wr(3'd0, 32'h0000_000F);
    chk_port(1'b0, 32'h0, "R10 restricted only");

    // R4 pin 5 (bit 26), code 01 edge, low register bits 21:20
    wr(3'd3, 32'h0010_0000);
    chk(3'd3, 32'h0010_0000, "R2 cfg_lo readback");
    wr(3'd1, 32'h0400_0000);
    setpin(26, 1'b1);
    tick(1);
    chk(3'd2, 32'h0, "R11 not yet after two edges");
    chk(3'd2, 32'h0400_0000, "R4 rising sets pin5");
    chk_port(1'b1, 32'h1, "R8 irq high");
    wr(3'd1, 32'h0);
    chk_port(1'b1, 32'h0, "R8 masked irq low");
    wr(3'd1, 32'h0400_0000);
    wr(3'd2, 32'h0);
    chk(3'd2, 32'h0400_0000, "R7 zero write keeps");
    wr(3'd2, 32'h0400_0000);
    chk(3'd2, 32'h0, "R7 one clears");
    chk_port(1'b1, 32'h0, "R8 irq low after clear");
    setpin(26, 1'b0);
    tick(4);
    chk(3'd2, 32'h0, "R4 falling ignored");

    // R5 pin 20 (bit 11), code 10 edge, high register bits 23:22
    wr(3'd4, 32'h0080_0000);
    chk(3'd4, 32'h0080_0000, "R2 cfg_hi readback");
    setpin(11, 1'b1);
    tick(4);
    chk(3'd2, 32'h0, "R5 rising ignored");
    setpin(11, 1'b0);
    tick(3);
    chk(3'd2, 32'h0000_0800, "R5 falling sets pin20 (R2)");
    wr(3'd2, 32'h0000_0800);

    // R3 pin 16 (bit 15), code 00
    setpin(15, 1'b1);
    tick(3);
    chk(3'd2, 32'h0000_8000, "R3 rising");
    wr(3'd2, 32'h0000_8000);
    setpin(15, 1'b0);
    tick(3);
    chk(3'd2, 32'h0000_8000, "R3 falling");
    wr(3'd2, 32'h0000_8000);
    chk(3'd2, 32'h0, "R7 cleared pin16");

    // R6 pin 31 (bit 0), code 11
    wr(3'd4, 32'h0080_0003);
    setpin(0, 1'b1);
    tick(4);
    setpin(0, 1'b0);
    tick(4);
    chk(3'd2, 32'h0, "R6 reserved no event");

    // R9 level modes: pin 2 (bit 29) high, pin 3 (bit 28) low
    wr(3'd5, 32'h3000_0000);
    chk(3'd5, 32'h3000_0000, "R4 lvl readback");
    wr(3'd3, 32'h0410_0000);
    setpin(29, 1'b1);
    tick(3);
    chk(3'd2, 32'h2000_0000, "R4 high level sets");
    wr(3'd2, 32'h2000_0000);
    chk(3'd2, 32'h2000_0000, "R9 set wins over clear");
    setpin(29, 1'b0);
    tick(4);
    wr(3'd2, 32'h2000_0000);
    chk(3'd2, 32'h0, "R9 clears once level gone");
    tick(3);
    chk(3'd2, 32'h0, "R9 stays clear");
    wr(3'd3, 32'h0610_0000);
    tick(3);
    chk(3'd2, 32'h1000_0000, "R5 low level sets");
    setpin(28, 1'b1);
    tick(4);
    wr(3'd2, 32'h1000_0000);
    chk(3'd2, 32'h0, "R5 low level released");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule